// File: doc/BRIEF.md
# Directory-Based Write Coherence Controller

This block serves writes in a small shared-memory multiprocessor whose caches are write-through. It holds a directory with one sharer bit-vector per tracked line and a single write sequencer. A processor starts a write by presenting an exclusive-read request carrying its processor number, the line index and the new data. The directory answers with the set of other processors that hold the line, then rewrites its entry. The sequencer then performs the coherence step for the requester and finishes with a write of the line to memory.

Two protocol modes are available, chosen per request by the `mode_upd` input at the cycle the request is accepted. In invalidate mode, the entry collapses to the requester alone. Every returned sharer gets an invalidate pulse, and the requester's cache write waits until each of those sharers has acknowledged. In update mode, the requester is added to the entry and no sharer is removed. The requester's cache is written first, and the new data is then pushed to every returned sharer. When the returned set is empty, the coherence step is skipped. A line that has a sequence in flight is marked busy, and no new request is accepted while any sequence runs.

Top module: `dwc_top`

## Requirements
- R1: After reset `req_ready` is high, every pulse output (`rsp_valid`, `coh_inv`, `coh_upd`, `cwr_valid`, `mem_wr_valid`) is low, and every directory entry is empty.
- R2: One cycle after a request is accepted (`req_valid` and `req_ready` high at a clock edge), `rsp_valid` is high for exactly one cycle. `rsp_sharers` then carries the line's entry with the requester's own bit cleared, where bit i stands for processor i.
- R3: An accepted request in invalidate mode (`mode_upd`=0) leaves the line's entry holding only the requester's bit.
- R4: An accepted request in update mode (`mode_upd`=1) leaves the line's entry as the old entry with the requester's bit added.
- R5: In invalidate mode with a non-empty returned set, `coh_inv` equals that set for one cycle, in the cycle after `rsp_valid`, and `coh_line` gives the line.
- R6: In invalidate mode, `cwr_valid` rises in the cycle after the clock edge at which the last outstanding sharer's `coh_ack` bit is seen. Acknowledgements from processors not in the returned set, repeated acknowledgements, and acknowledgements arriving during the `coh_inv` cycle are not counted.
- R7: In update mode with a non-empty returned set, `cwr_valid` is high in the cycle after `rsp_valid`, and `coh_upd` equals the returned set in the following cycle, with `coh_data` equal to the request data.
- R8: `mem_wr_valid` is high for one cycle directly after the last step of the sequence (the cache write in invalidate mode, the update pulse in update mode), with `mem_wr_line` and `mem_wr_data` equal to the request's line and data.
- R9: When the returned set is empty, no `coh_inv` or `coh_upd` pulse is made. `cwr_valid` follows `rsp_valid` directly, and `mem_wr_valid` follows in the next cycle.
- R10: `req_ready` is low from the cycle after acceptance through the memory-write cycle and is high again in the cycle after it.
- R11: `cwr_pid`, `cwr_line` and `cwr_data` equal the requester's number, line and data. A change of `mode_upd` after acceptance has no effect on the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_upd | input | 1 | Protocol of the request being accepted: 0 invalidate, 1 update |
| req_valid | input | 1 | Exclusive-read (write) request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_pid | input | PIDW | Requesting processor number |
| req_line | input | LINEW | Line index |
| req_data | input | DW | New line data |
| rsp_valid | output | 1 | Directory reply pulse |
| rsp_sharers | output | NPROC | Sharers of the line other than the requester |
| coh_inv | output | NPROC | Invalidate pulse, one bit per processor |
| coh_upd | output | NPROC | Data-update pulse, one bit per processor |
| coh_line | output | LINEW | Line of the coherence message |
| coh_data | output | DW | Data of the update message |
| coh_ack | input | NPROC | Invalidate acknowledgement, one bit per processor |
| cwr_valid | output | 1 | Requester cache write pulse |
| cwr_pid | output | PIDW | Processor whose cache is written |
| cwr_line | output | LINEW | Line of the cache write |
| cwr_data | output | DW | Data of the cache write |
| mem_wr_valid | output | 1 | Memory write-through pulse |
| mem_wr_line | output | LINEW | Line written to memory |
| mem_wr_data | output | DW | Data written to memory |

## Verification
The hardest situation to reach is an invalidate sequence with several sharers whose acknowledgements arrive split over cycles, mixed with a stray acknowledgement from a non-sharer and a repeat from one already counted. The stimulus builds that state only through the ports. A chain of update-mode writes to one line grows its entry to three sharers, and a fourth processor then writes in invalidate mode while the bench feeds the acknowledgements in three partial steps. Each cycle, the bench checks that the cache write has not yet started.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

   typedef enum logic [2:0] {
      S_IDLE  = 3'd0,
      S_LOOK  = 3'd1,
      S_ISEND = 3'd2,
      S_IWAIT = 3'd3,
      S_CWR   = 3'd4,
      S_USEND = 3'd5,
      S_MEM   = 3'd6
   } seq_st_t;

   function automatic logic [5:0] pop32(input logic [31:0] v);
      logic [5:0] n;
      n = '0;
      for (int i = 0; i < 32; i++) n = n + {5'd0, v[i]};
      return n;
   endfunction

endpackage

// File: rtl/dwc_dir.sv
module dwc_dir #(
   parameter int NPROC = 4,
   parameter int NLINE = 8,
   parameter int LINEW = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LINEW-1:0] rd_line,
   output logic [NPROC-1:0] rd_vec,
   input  logic             wr_en,
   input  logic [LINEW-1:0] wr_line,
   input  logic [NPROC-1:0] wr_vec,
   input  logic             bset,
   input  logic [LINEW-1:0] bset_line,
   input  logic             bclr,
   input  logic [LINEW-1:0] bclr_line,
   output logic [NLINE-1:0] busy_q
);

   logic [NPROC-1:0] ent_q [NLINE];

   for (genvar l = 0; l < NLINE; l++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_q[l]  <= '0;
            busy_q[l] <= 1'b0;
         end else begin
            if (wr_en && (wr_line == LINEW'(l))) ent_q[l] <= wr_vec;
            if (bset && (bset_line == LINEW'(l)))      busy_q[l] <= 1'b1;
            else if (bclr && (bclr_line == LINEW'(l))) busy_q[l] <= 1'b0;
         end
      end
   end

   assign rd_vec = ent_q[rd_line];

   // R10: one sequencer, so never more than one line busy
   a_r10_single_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(busy_q) <= 1);

endmodule

// File: rtl/dwc_ackcnt.sv
module dwc_ackcnt
   import dwc_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int CW    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [NPROC-1:0] load_mask,
   input  logic             active,
   input  logic [NPROC-1:0] ack,
   output logic             last
);

   logic [NPROC-1:0] pend_q;
   logic [CW-1:0]    cnt_q;
   logic [NPROC-1:0] got;
   logic [CW-1:0]    got_n;

   assign got   = active ? (ack & pend_q) : '0;
   assign got_n = CW'(pop32(32'(got)));
   assign last  = active && (cnt_q != '0) && (got_n == cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         cnt_q  <= '0;
      end else if (load) begin
         pend_q <= load_mask;
         cnt_q  <= CW'(pop32(32'(load_mask)));
      end else if (active) begin
         pend_q <= pend_q & ~got;
         cnt_q  <= cnt_q - got_n;
      end
   end

   // R6: counted acknowledgements never exceed those outstanding
   a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (got_n <= cnt_q));

endmodule

// File: rtl/dwc_seq.sv
module dwc_seq
   import dwc_pkg::*;
#(
   parameter int NPROC = 4,
   parameter int LINEW = 3,
   parameter int PIDW  = 2,
   parameter int DW    = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_upd,
   input  logic             req_valid,
   input  logic             line_busy,
   output logic             req_ready,
   input  logic [PIDW-1:0]  req_pid,
   input  logic [LINEW-1:0] req_line,
   input  logic [DW-1:0]    req_data,
   input  logic [NPROC-1:0] dir_rd_vec,
   output logic [LINEW-1:0] cur_line,
   output logic             dir_wr_en,
   output logic [NPROC-1:0] dir_wr_vec,
   output logic             bset,
   output logic             bclr,
   output logic             cnt_load,
   output logic [NPROC-1:0] cnt_mask,
   output logic             cnt_active,
   input  logic             cnt_last,
   output logic             rsp_valid,
   output logic [NPROC-1:0] rsp_sharers,
   output logic [NPROC-1:0] coh_inv,
   output logic [NPROC-1:0] coh_upd,
   output logic [DW-1:0]    cur_data,
   output logic             cwr_valid,
   output logic [PIDW-1:0]  cwr_pid,
   output logic             mem_wr_valid
);

   seq_st_t          st_q, st_d;
   logic [PIDW-1:0]  pid_q;
   logic [LINEW-1:0] line_q;
   logic [DW-1:0]    data_q;
   logic             upd_q;
   logic [NPROC-1:0] oth_q;
   logic [NPROC-1:0] own_oh;
   logic [NPROC-1:0] oth_c;
   logic             accept;

   assign req_ready = (st_q == S_IDLE) && !line_busy;
   assign accept    = req_valid && req_ready;
   assign own_oh    = NPROC'(1) << pid_q;
   assign oth_c     = dir_rd_vec & ~own_oh;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         S_IDLE:  if (accept) st_d = S_LOOK;
         S_LOOK:  st_d = (!upd_q && (oth_c != '0)) ? S_ISEND : S_CWR;
         S_ISEND: st_d = S_IWAIT;
         S_IWAIT: if (cnt_last) st_d = S_CWR;
         S_CWR:   st_d = (upd_q && (oth_q != '0)) ? S_USEND : S_MEM;
         S_USEND: st_d = S_MEM;
         S_MEM:   st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         pid_q  <= '0;
         line_q <= '0;
         data_q <= '0;
         upd_q  <= 1'b0;
         oth_q  <= '0;
      end else begin
         st_q <= st_d;
         if (accept) begin
            pid_q  <= req_pid;
            line_q <= req_line;
            data_q <= req_data;
            upd_q  <= mode_upd;
         end
         if (st_q == S_LOOK) oth_q <= oth_c;
      end
   end

   assign cur_line     = line_q;
   assign cur_data     = data_q;
   assign cwr_pid      = pid_q;
   assign dir_wr_en    = (st_q == S_LOOK);
   assign dir_wr_vec   = upd_q ? (dir_rd_vec | own_oh) : own_oh;
   assign bset         = accept;
   assign bclr         = (st_q == S_MEM);
   assign cnt_load     = (st_q == S_LOOK) && !upd_q;
   assign cnt_mask     = oth_c;
   assign cnt_active   = (st_q == S_IWAIT);
   assign rsp_valid    = (st_q == S_LOOK);
   assign rsp_sharers  = (st_q == S_LOOK) ? oth_c : '0;
   assign coh_inv      = (st_q == S_ISEND) ? oth_q : '0;
   assign coh_upd      = (st_q == S_USEND) ? oth_q : '0;
   assign cwr_valid    = (st_q == S_CWR);
   assign mem_wr_valid = (st_q == S_MEM);

   a_r2_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   a_r10_no_ready_active: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_IDLE) |-> !req_ready);

   a_r8_mem_after_last: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr_valid |-> ($past(cwr_valid) || ($past(coh_upd) != '0)));

   a_r6_cwr_after_acks: assert property (@(posedge clk) disable iff (!rst_n)
      (cwr_valid && !upd_q && (oth_q != '0)) |-> $past(cnt_last));

   a_r3_inv_entry: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == S_LOOK) && !upd_q) |=> (dir_rd_vec == $past(own_oh)));

   a_r11_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != S_IDLE && st_q != S_LOOK) |-> $stable(upd_q));

endmodule

// File: rtl/dwc_top.sv
module dwc_top #(
   parameter int NPROC = 4,
   parameter int NLINE = 8,
   parameter int DW    = 16,
   localparam int PIDW  = (NPROC > 1) ? $clog2(NPROC) : 1,
   localparam int LINEW = (NLINE > 1) ? $clog2(NLINE) : 1,
   localparam int CW    = $clog2(NPROC + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_upd,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [PIDW-1:0]  req_pid,
   input  logic [LINEW-1:0] req_line,
   input  logic [DW-1:0]    req_data,
   output logic             rsp_valid,
   output logic [NPROC-1:0] rsp_sharers,
   output logic [NPROC-1:0] coh_inv,
   output logic [NPROC-1:0] coh_upd,
   output logic [LINEW-1:0] coh_line,
   output logic [DW-1:0]    coh_data,
   input  logic [NPROC-1:0] coh_ack,
   output logic             cwr_valid,
   output logic [PIDW-1:0]  cwr_pid,
   output logic [LINEW-1:0] cwr_line,
   output logic [DW-1:0]    cwr_data,
   output logic             mem_wr_valid,
   output logic [LINEW-1:0] mem_wr_line,
   output logic [DW-1:0]    mem_wr_data
);

   if (NPROC < 2 || NPROC > 32) begin : g_bad_nproc
      $error("dwc_top: NPROC must lie in 2..32");
   end
   if (NLINE < 1 || NLINE > 1024) begin : g_bad_nline
      $error("dwc_top: NLINE must lie in 1..1024");
   end
   if (DW < 1) begin : g_bad_dw
      $error("dwc_top: DW must be positive");
   end

   logic [NPROC-1:0] dir_rd_vec, dir_wr_vec, cnt_mask;
   logic [LINEW-1:0] cur_line;
   logic [DW-1:0]    cur_data;
   logic [NLINE-1:0] busy_q;
   logic             dir_wr_en, bset, bclr, cnt_load, cnt_active, cnt_last;

   dwc_dir #(.NPROC(NPROC), .NLINE(NLINE), .LINEW(LINEW)) u_dir (
      .clk(clk), .rst_n(rst_n),
      .rd_line(cur_line), .rd_vec(dir_rd_vec),
      .wr_en(dir_wr_en), .wr_line(cur_line), .wr_vec(dir_wr_vec),
      .bset(bset), .bset_line(req_line),
      .bclr(bclr), .bclr_line(cur_line),
      .busy_q(busy_q)
   );

   dwc_ackcnt #(.NPROC(NPROC), .CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .load(cnt_load), .load_mask(cnt_mask),
      .active(cnt_active), .ack(coh_ack), .last(cnt_last)
   );

   dwc_seq #(.NPROC(NPROC), .LINEW(LINEW), .PIDW(PIDW), .DW(DW)) u_seq (
      .clk(clk), .rst_n(rst_n), .mode_upd(mode_upd),
      .req_valid(req_valid), .line_busy(busy_q[req_line]), .req_ready(req_ready),
      .req_pid(req_pid), .req_line(req_line), .req_data(req_data),
      .dir_rd_vec(dir_rd_vec), .cur_line(cur_line),
      .dir_wr_en(dir_wr_en), .dir_wr_vec(dir_wr_vec),
      .bset(bset), .bclr(bclr),
      .cnt_load(cnt_load), .cnt_mask(cnt_mask),
      .cnt_active(cnt_active), .cnt_last(cnt_last),
      .rsp_valid(rsp_valid), .rsp_sharers(rsp_sharers),
      .coh_inv(coh_inv), .coh_upd(coh_upd), .cur_data(cur_data),
      .cwr_valid(cwr_valid), .cwr_pid(cwr_pid), .mem_wr_valid(mem_wr_valid)
   );

   assign coh_line    = cur_line;
   assign coh_data    = cur_data;
   assign cwr_line    = cur_line;
   assign cwr_data    = cur_data;
   assign mem_wr_line = cur_line;
   assign mem_wr_data = cur_data;

endmodule

// File: tb/sim_dwc_top.sv
module sim_dwc_top;

   localparam int NPROC = 4;
   localparam int NLINE = 8;
   localparam int DW    = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_upd = 1'b0, req_valid = 1'b0;
   logic [1:0] req_pid = '0;
   logic [2:0] req_line = '0;
   logic [DW-1:0] req_data = '0;
   logic [NPROC-1:0] coh_ack = '0;
   logic req_ready, rsp_valid, cwr_valid, mem_wr_valid;
   logic [NPROC-1:0] rsp_sharers, coh_inv, coh_upd;
   logic [2:0] coh_line, cwr_line, mem_wr_line;
   logic [DW-1:0] coh_data, cwr_data, mem_wr_data;
   logic [1:0] cwr_pid;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   logic [NPROC-1:0] mdir [NLINE];

   always #5 clk = ~clk;

   dwc_top #(.NPROC(NPROC), .NLINE(NLINE), .DW(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .mode_upd(mode_upd),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_pid(req_pid), .req_line(req_line), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_sharers(rsp_sharers),
      .coh_inv(coh_inv), .coh_upd(coh_upd), .coh_line(coh_line), .coh_data(coh_data),
      .coh_ack(coh_ack),
      .cwr_valid(cwr_valid), .cwr_pid(cwr_pid), .cwr_line(cwr_line), .cwr_data(cwr_data),
      .mem_wr_valid(mem_wr_valid), .mem_wr_line(mem_wr_line), .mem_wr_data(mem_wr_data)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 5000) begin
         bad = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   task automatic chkv(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // full compare of the pulse outputs in the current cycle
   task automatic chk(input string tag, input logic rr, input logic rv,
                      input logic [NPROC-1:0] rs, input logic [NPROC-1:0] ci,
                      input logic [NPROC-1:0] cu, input logic cw, input logic mw);
      chkv({tag, " req_ready"},    32'(req_ready),    32'(rr));
      chkv({tag, " rsp_valid"},    32'(rsp_valid),    32'(rv));
      chkv({tag, " rsp_sharers"},  32'(rsp_sharers),  32'(rs));
      chkv({tag, " coh_inv"},      32'(coh_inv),      32'(ci));
      chkv({tag, " coh_upd"},      32'(coh_upd),      32'(cu));
      chkv({tag, " cwr_valid"},    32'(cwr_valid),    32'(cw));
      chkv({tag, " mem_wr_valid"}, 32'(mem_wr_valid), 32'(mw));
   endtask

   // one whole write; acks for invalidate mode are given in up to three steps
   task automatic do_write(input logic [1:0] pid, input logic [2:0] line,
                           input logic [DW-1:0] data, input logic upd, input logic flip,
                           input logic [NPROC-1:0] a0, input logic [NPROC-1:0] a1,
                           input logic [NPROC-1:0] a2);
      logic [NPROC-1:0] own, oth, rem;
      logic [NPROC-1:0] steps [3];
      steps[0] = a0; steps[1] = a1; steps[2] = a2;
      own = NPROC'(1) << pid;
      oth = mdir[line] & ~own;
      mdir[line] = upd ? (mdir[line] | own) : own;
      chk("R10 idle before request", 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b0);
      req_valid = 1'b1; req_pid = pid; req_line = line; req_data = data; mode_upd = upd;
      @(negedge clk);
      req_valid = 1'b0;
      if (flip) mode_upd = ~upd;
      chk("R2 directory reply", 1'b0, 1'b1, oth, '0, '0, 1'b0, 1'b0);
      @(negedge clk);
      if (!upd && oth != '0) begin
         coh_ack = oth;   // R6: acks in the send cycle are not counted
         chk("R5 invalidate fanout", 1'b0, 1'b0, '0, oth, '0, 1'b0, 1'b0);
         chkv("R5 coh_line", 32'(coh_line), 32'(line));
         @(negedge clk);
         coh_ack = '0;
         rem = oth;
         for (int s = 0; s < 3; s++) begin
            chk("R6 waiting for acks", 1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b0);
            coh_ack = steps[s];
            @(negedge clk);
            coh_ack = '0;
            rem = rem & ~steps[s];
            if (rem == '0) break;
         end
      end
      chk("R9 R7 R6 cache write", 1'b0, 1'b0, '0, '0, '0, 1'b1, 1'b0);
      chkv("R11 cwr_pid", 32'(cwr_pid), 32'(pid));
      chkv("R11 cwr_line", 32'(cwr_line), 32'(line));
      chkv("R11 cwr_data", 32'(cwr_data), 32'(data));
      @(negedge clk);
      if (upd && oth != '0) begin
         chk("R7 update fanout", 1'b0, 1'b0, '0, '0, oth, 1'b0, 1'b0);
         chkv("R7 coh_data", 32'(coh_data), 32'(data));
         @(negedge clk);
      end
      chk("R8 memory write", 1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b1);
      chkv("R8 mem_wr_line", 32'(mem_wr_line), 32'(line));
      chkv("R8 mem_wr_data", 32'(mem_wr_data), 32'(data));
      @(negedge clk);
      chk("R10 ready after sequence", 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b0);
   endtask

   initial begin
      for (int l = 0; l < NLINE; l++) mdir[l] = '0;
      #23;
      chk("R1 in reset", 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 after reset", 1'b1, 1'b0, '0, '0, '0, 1'b0, 1'b0);
      // R9: empty entry, update mode
      do_write(2'd0, 3'd3, 16'hA001, 1'b1, 1'b0, '0, '0, '0);
      // R4 R7: update mode grows the entry
      do_write(2'd1, 3'd3, 16'hA002, 1'b1, 1'b0, '0, '0, '0);
      do_write(2'd2, 3'd3, 16'hA003, 1'b1, 1'b0, '0, '0, '0);
      // R5 R6: split acks with a stray (P3) and a repeated (P0) ack
      do_write(2'd3, 3'd3, 16'hB004, 1'b0, 1'b0, 4'b1001, 4'b0001, 4'b0110);
      // R3 R9: entry now only the requester, so nothing to invalidate
      do_write(2'd3, 3'd3, 16'hB005, 1'b0, 1'b0, '0, '0, '0);
      // other line stays independent
      do_write(2'd0, 3'd5, 16'hC006, 1'b0, 1'b0, '0, '0, '0);
      // R11: mode input flipped after acceptance
      do_write(2'd1, 3'd3, 16'hD007, 1'b0, 1'b1, 4'b1000, '0, '0);
      // R3 check through the reply of the next request, again with a flip
      do_write(2'd2, 3'd3, 16'hE008, 1'b1, 1'b1, '0, '0, '0);
      do_write(2'd1, 3'd5, 16'hF009, 1'b1, 1'b0, '0, '0, '0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule